// File: doc/BRIEF.md
# Palette-Indexed VGA Scanout Engine

This block generates a 640x480 raster at standard 60 Hz timing with active-low horizontal and vertical sync. Inside the raster it shows a 320x200 image whose top-left corner sits at column 160, row 140. The image is stored as one 8-bit colour index per pixel. For each pixel in the window, the block issues a read address to an external synchronous frame-buffer RAM. It then maps the returned index to a 24-bit colour through an internal 256-entry palette, which software may rewrite at any time.

Outside the window, and throughout blanking, the colour outputs are black. Both reads, the frame-buffer read and the palette read, take one cycle each. The sync and window flags are delayed by two cycles so that colour, sync and screen position stay in step.

A synchronous reset returns the raster to its first pixel and also clears the frame-buffer fetch counter. Because both restart together, reasserting reset in mid-frame can never leave the picture shifted by a constant number of pixels.

Top module: `idx_vga_scan`

## Requirements
- R1: While `rst` is sampled high, the cycle that follows shows black RGB with `hsync` and `vsync` high. The raster position after release is column 0, row 0, and its colour appears at the outputs two cycles later.
- R2: A line lasts H_VIS+H_FP+H_SYNC+H_BP cycles. `hsync` is low, for H_SYNC cycles, exactly when the column lies in [H_VIS+H_FP, H_VIS+H_FP+H_SYNC).
- R3: A frame lasts V_VIS+V_FP+V_SYNC+V_BP lines. `vsync` is low exactly when the row lies in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC).
- R4: While the position is inside the window, `fb_addr` equals (row-WIN_Y0)*WIN_W + (col-WIN_X0), in the same cycle.
- R5: RGB output is palette[fb_idx], with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. It appears two cycles after the cycle whose position issued the fetch, aligned with that position's sync values.
- R6: RGB is zero for every position outside the window, including all blanking positions.
- R7: A palette write applies to reads issued from the next cycle on. A read of the same entry in the write's own cycle returns the old colour.
- R8: After reset is asserted in mid-frame, the first window pixel of the restarted frame fetches address 0, and every later window pixel fetches its own address, with no residual offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | IDX_W | Palette entry to write |
| pal_rgb | input | 24 | Colour to write, {R,G,B} |
| fb_addr | output | AW | Frame-buffer read address |
| fb_idx | input | IDX_W | Colour index from frame buffer, one cycle after address |
| vga_r | output | 8 | Red |
| vga_g | output | 8 | Green |
| vga_b | output | 8 | Blue |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |

## Verification
Two events can land on the same cycle: a palette write, and the palette read of that same entry by the scanout pipeline. The bench fills the frame buffer with one index and writes a new colour to that entry in exactly the cycle in which the first window pixel's index reaches the palette. It then expects the old colour on that pixel and the new colour on the next one. The second coincidence is a reset that lands while the fetch counter is partway through the window. The bench judges it by checking every window address and pixel of the restarted frames against positions counted from the release.

// File: rtl/idx_vga_scan.sv
module idx_vga_scan #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int WIN_X0 = 160,
  parameter int WIN_Y0 = 140,
  parameter int WIN_W  = 320,
  parameter int WIN_H  = 200,
  parameter int IDX_W  = 8,
  localparam int AW    = $clog2(WIN_W * WIN_H)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pal_we,
  input  logic [IDX_W-1:0] pal_idx,
  input  logic [23:0]      pal_rgb,
  output logic [AW-1:0]    fb_addr,
  input  logic [IDX_W-1:0] fb_idx,
  output logic [7:0]       vga_r,
  output logic [7:0]       vga_g,
  output logic [7:0]       vga_b,
  output logic             hsync,
  output logic             vsync
);
  localparam int HT  = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT  = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HCW = $clog2(HT);
  localparam int VCW = $clog2(VT);
  localparam logic [HCW-1:0] H_LAST = HCW'(HT - 1);
  localparam logic [VCW-1:0] V_LAST = VCW'(VT - 1);
  localparam logic [HCW-1:0] HS_ON  = HCW'(H_VIS + H_FP);
  localparam logic [HCW-1:0] HS_OFF = HCW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VCW-1:0] VS_ON  = VCW'(V_VIS + V_FP);
  localparam logic [VCW-1:0] VS_OFF = VCW'(V_VIS + V_FP + V_SYNC);
  localparam logic [HCW-1:0] X_LO   = HCW'(WIN_X0);
  localparam logic [HCW-1:0] X_HI   = HCW'(WIN_X0 + WIN_W);
  localparam logic [VCW-1:0] Y_LO   = VCW'(WIN_Y0);
  localparam logic [VCW-1:0] Y_HI   = VCW'(WIN_Y0 + WIN_H);

  logic [HCW-1:0] hc;
  logic [VCW-1:0] vc;
  logic [AW-1:0]  fcnt;
  logic [1:0]     hs_d, vs_d, win_d;
  logic [23:0]    pal [2**IDX_W];
  logic [23:0]    pal_q;

  wire line_end  = (hc == H_LAST);
  wire frame_end = line_end && (vc == V_LAST);
  wire in_win    = (hc >= X_LO) && (hc < X_HI) && (vc >= Y_LO) && (vc < Y_HI);
  wire hs_now    = !((hc >= HS_ON) && (hc < HS_OFF));
  wire vs_now    = !((vc >= VS_ON) && (vc < VS_OFF));

  always_ff @(posedge clk) begin
    if (rst) begin
      hc    <= '0;
      vc    <= '0;
      fcnt  <= '0;
      hs_d  <= '1;
      vs_d  <= '1;
      win_d <= '0;
    end else begin
      hc <= line_end ? '0 : hc + 1'b1;
      if (line_end) vc <= (vc == V_LAST) ? '0 : vc + 1'b1;
      if (frame_end)   fcnt <= '0;
      else if (in_win) fcnt <= fcnt + 1'b1;
      hs_d  <= {hs_d[0], hs_now};
      vs_d  <= {vs_d[0], vs_now};
      win_d <= {win_d[0], in_win};
    end
  end

  always_ff @(posedge clk) begin
    if (pal_we) pal[pal_idx] <= pal_rgb;
    pal_q <= pal[fb_idx];
  end

  assign fb_addr = fcnt;
  assign {vga_r, vga_g, vga_b} = win_d[1] ? pal_q : 24'd0;
  assign hsync = hs_d[1];
  assign vsync = vs_d[1];
endmodule

module idx_vga_scan_chk #(
  parameter int HCW = 10,
  parameter int VCW = 10,
  parameter int AW  = 16,
  parameter int X0  = 160,
  parameter int Y0  = 140
) (
  input logic           clk,
  input logic           rst,
  input logic           hsync,
  input logic           vsync,
  input logic [23:0]    rgb,
  input logic           in_win,
  input logic [HCW-1:0] hc,
  input logic [VCW-1:0] vc,
  input logic [AW-1:0]  fb_addr
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (hsync && vsync && rgb == 24'd0)); // R1
  AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync) |=> !hsync); // R2
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
    (!hsync || !vsync) |-> rgb == 24'd0); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_win && $past(in_win)) |-> fb_addr == AW'($past(fb_addr) + 1'b1)); // R4
  AST_ADDR_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (in_win && hc == HCW'(X0) && vc == VCW'(Y0)) |-> fb_addr == '0); // R8
endmodule

bind idx_vga_scan idx_vga_scan_chk #(
  .HCW(HCW), .VCW(VCW), .AW(AW), .X0(WIN_X0), .Y0(WIN_Y0)
) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
  .rgb({vga_r, vga_g, vga_b}), .in_win(in_win), .hc(hc), .vc(vc),
  .fb_addr(fb_addr)
);

// File: tb/idx_vga_scan_test.sv
module idx_vga_scan_test;
  localparam int HV = 16, HF = 2, HSY = 3, HB = 3;
  localparam int VV = 12, VF = 1, VSY = 2, VB = 2;
  localparam int X0 = 4, Y0 = 3, W = 8, H = 6;
  localparam int HT = HV + HF + HSY + HB;
  localparam int VT = VV + VF + VSY + VB;
  localparam int FT = HT * VT;
  localparam int AW = $clog2(W * H);

  logic clk = 0;
  logic rst = 1;
  logic pal_we = 0;
  logic [7:0] pal_idx = 0;
  logic [23:0] pal_rgb = 0;
  logic [AW-1:0] fb_addr;
  logic [7:0] fb_idx;
  logic [7:0] vga_r, vga_g, vga_b;
  logic hsync, vsync;

  logic [7:0]  fbm [64];
  logic [23:0] palm [256];
  int n = 0, tests = 0, fails = 0;
  bit chk_en = 0;
  string tag_addr = "R4";

  always #4 clk = ~clk;
  always @(posedge clk) fb_idx <= fbm[fb_addr];

  idx_vga_scan #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HSY), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VSY), .V_BP(VB),
    .WIN_X0(X0), .WIN_Y0(Y0), .WIN_W(W), .WIN_H(H), .IDX_W(8)
  ) uut (
    .clk(clk), .rst(rst), .pal_we(pal_we), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .fb_addr(fb_addr), .fb_idx(fb_idx), .vga_r(vga_r), .vga_g(vga_g),
    .vga_b(vga_b), .hsync(hsync), .vsync(vsync)
  );

  task automatic chk(input string r, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", r, n, got, exp);
    end
  endtask

  function automatic bit win(input int hc, input int vc);
    return hc >= X0 && hc < X0 + W && vc >= Y0 && vc < Y0 + H;
  endfunction

  task automatic check_cycle();
    int m, hc, vc, pc, pv;
    bit ehs, evs;
    int ergb;
    if (n < 2) begin
      chk("R1", {vga_r, vga_g, vga_b}, 0);
      chk("R1", {hsync, vsync}, 3);
    end else begin
      m = (n - 2) % FT;
      hc = m % HT;
      vc = m / HT;
      ehs = !(hc >= HV + HF && hc < HV + HF + HSY);
      evs = !(vc >= VV + VF && vc < VV + VF + VSY);
      ergb = win(hc, vc) ? int'(palm[fbm[(vc - Y0) * W + (hc - X0)]]) : 0;
      chk("R2", hsync, ehs);
      chk("R3", vsync, evs);
      chk(win(hc, vc) ? "R5" : "R6", {vga_r, vga_g, vga_b}, ergb);
    end
    pc = (n % FT) % HT;
    pv = (n % FT) / HT;
    if (win(pc, pv)) chk(tag_addr, fb_addr, (pv - Y0) * W + (pc - X0));
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst) begin
      chk("R1", {vga_r, vga_g, vga_b}, 0);
      chk("R1", {hsync, vsync}, 3);
    end else begin
      n++;
      if (chk_en) check_cycle();
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) fbm[i] = 8'((i * 37 + 11) & 255);
    cyc(); cyc();
    for (int i = 0; i < 256; i++) begin
      pal_we = 1; pal_idx = 8'(i); pal_rgb = 24'(i * 65793) ^ 24'h5A3C1F;
      palm[i] = pal_rgb;
      cyc();
    end
    pal_we = 0;
    rst = 0; n = 0; chk_en = 1;
    chk("R4", fb_addr, 0);
    repeat (2 * FT) cyc();

    // R7: rewrite palette during vertical blanking, then a full frame
    while (n % FT != VV * HT) cyc();
    for (int k = 0; k < W * H; k++) begin
      pal_we = 1; pal_idx = fbm[k]; pal_rgb = 24'(k * 4099 + 777);
      cyc();
      palm[fbm[k]] = 24'(k * 4099 + 777);
    end
    pal_we = 0;
    repeat (FT) cyc();

    // R8: reset in the middle of the window, then check restarted frames
    while (n % FT != 8 * HT + 8) cyc();
    rst = 1;
    repeat (3) cyc();
    rst = 0; n = 0; tag_addr = "R8";
    repeat (2 * FT) cyc();

    // R7: write collides with the read of the same entry
    chk_en = 0;
    rst = 1;
    for (int i = 0; i < 64; i++) fbm[i] = 8'd5;
    pal_we = 1; pal_idx = 8'd5; pal_rgb = 24'hA1B2C3;
    cyc();
    pal_we = 0;
    cyc();
    rst = 0; n = 0;
    while (n < Y0 * HT + X0 + 1) cyc();
    pal_we = 1; pal_idx = 8'd5; pal_rgb = 24'h0D0E0F;
    cyc();
    pal_we = 0;
    chk("R7", {vga_r, vga_g, vga_b}, 24'hA1B2C3);
    cyc();
    chk("R7", {vga_r, vga_g, vga_b}, 24'h0D0E0F);
    cyc();
    chk("R7", {vga_r, vga_g, vga_b}, 24'h0D0E0F);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule